// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block chooses which of two free-running clocks drives the core: a frequency-locked-loop clock, called the loop clock here, or a high-frequency oscillator clock. After power-on reset, and again after every stop-mode exit, the core runs on the loop clock. Meanwhile a counter clocked by the oscillator counts a warmup period. Once that period has run out, the block hands the core over to the oscillator by itself, unless software has asked to stay on the loop clock.

Every change of source passes through a gap in which both clock gates are closed. Each gate opens and closes only on the falling edge of its own clock. As a result the output never carries a pulse that is shorter than half a period of either clock.

A status output reports whether the loop clock is still in charge. It changes only at the real handover, so it can trail the software select bit for a full warmup period. A run-enable output holds execution back after reset and after wake. A request to power the oscillator down is honoured only while the loop clock is in charge and the select bit asks for it.

Top module: `clksw_top`

## Requirements
- R1: While `porN` is low, `runEn` is 0 and `loopActive` is 1. After `porN` is released, the loop clock drives `sysClk` and `runEn` rises on the fourth rising `loopClk` edge after the release.
- R2: With `oscPresent` at 1 and the select bit at 0, once the counter has seen `WARM_CYCLES` oscillator edges, `sysClk` moves to the oscillator clock without any outside action and `loopActive` reads 0.
- R3: While `oscPresent` is 0 the warmup never ends, so `sysClk` stays on the loop clock and `loopActive` stays 1 for as long as that lasts.
- R4: Writing 1 to the select bit (`selWrEn` with `selWrData`=1) brings `sysClk` back to the loop clock within a few cycles, and `loopActive` returns to 1.
- R5: When the select bit is cleared while a warmup is still in progress, `loopActive` stays 1 and `sysClk` stays on the loop clock until the warmup ends. After that, `loopActive` reads 0.
- R6: The select bit changes only through a write. Stop and wake leave it untouched, and only power-on reset clears it to 0.
- R7: While running, `stopReq` makes `runEn` fall on the next `loopClk` edge and stops `sysClk`. While running, `wakeReq` has no effect, and when `stopReq` and `wakeReq` arrive in the same cycle, the stop takes effect.
- R8: While stopped, `wakeReq` makes `runEn` rise on the fourth rising `loopClk` edge after the edge that samples it. Execution resumes on the loop clock. With the select bit at 0, the warmup restarts from zero.
- R9: A write of 1 to the oscillator disable (`hfWrEn` with `hfWrData`=1) is accepted only when `loopActive` is 1 and the select bit already reads 1. A write of 0 is always accepted. While `oscPowerDown` is 1, the warmup is held at zero and the oscillator is not selected.
- R10: At no time do both clock gates stand open together, and every high or low phase of `sysClk` lasts at least half a period of the faster clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| loopClk | input | 1 | Frequency-locked-loop clock; also clocks the control logic |
| oscClk | input | 1 | High-frequency oscillator clock; clocks the warmup counter |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| oscPresent | input | 1 | 1 when the oscillator is actually oscillating; while 0 the warmup counter does not advance |
| stopReq | input | 1 | Enter stop mode (sampled on loopClk) |
| wakeReq | input | 1 | Leave stop mode (sampled on loopClk) |
| selWrEn | input | 1 | Write strobe for the loop-clock select bit |
| selWrData | input | 1 | Value written to the select bit; 1 forces the loop clock |
| hfWrEn | input | 1 | Write strobe for the oscillator disable |
| hfWrData | input | 1 | Value written to the oscillator disable; 1 requests power-down |
| sysClk | output | 1 | Selected, glitch-free core clock |
| loopActive | output | 1 | 1 unless the oscillator is the current source |
| runEn | output | 1 | 1 when execution may proceed |
| oscPowerDown | output | 1 | 1 when the oscillator has been switched off |

## Verification
Two pairs of events can land in the same `loopClk` cycle. The first pair is a stop request and a wake request. The bench raises both in one cycle while the block is running and expects `runEn` to be low one edge later. The second pair is an oscillator-disable write and a select-bit write. From the oscillator state, the bench issues both writes in one cycle. The disable must be judged against the select value from before the write, so `oscPowerDown` must stay 0, while the select write still sends the clock back to the loop source. The clock source is judged by counting `sysClk` edges over a fixed window, and runt pulses are caught by timing every phase of `sysClk`.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

  // cycles between wake (or reset release) and execution restart
  localparam int RESUME_CYCLES = 4;

  // control -> datapath strobes
  typedef struct packed {
    logic wantLoop;
    logic wantOsc;
    logic warmClear;
  } clksw_cmd_t;

  // datapath -> control feedback, all in the loop-clock domain
  typedef struct packed {
    logic warmDone;
    logic loopGateOn;
    logic oscGateOn;
  } clksw_stat_t;

  typedef enum logic [1:0] {
    RUN_RESUME  = 2'd0,
    RUN_ACTIVE  = 2'd1,
    RUN_STOPPED = 2'd2
  } run_state_t;

  typedef enum logic [1:0] {
    SRC_LOOP = 2'd0,
    SRC_GAP  = 2'd1,
    SRC_OSC  = 2'd2,
    SRC_OFF  = 2'd3
  } src_state_t;

endpackage

// File: rtl/clksw_sync.sv
module clksw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES < 2) begin : g_bad
      initial $display("clksw_sync: STAGES must be at least 2");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/clksw_datapath.sv
module clksw_datapath
  import clksw_pkg::*;
#(
  parameter int WARM_CYCLES = 65536,
  parameter int SYNC_STAGES = 2
) (
  input  logic        loopClk,
  input  logic        oscClk,
  input  logic        porN,
  input  logic        oscPresent,
  input  clksw_cmd_t  cmd,
  output clksw_stat_t stat,
  output logic        sysClk
);
  localparam int CW = $clog2(WARM_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(WARM_CYCLES - 1);

  logic          warmClr;
  logic [1:0]    clrPipe;
  logic          oscClr;
  logic [CW-1:0] warmCnt;
  logic          warmDoneOsc;

  assign warmClr = cmd.warmClear;

  // clear asserts at once, releases on the oscillator clock
  always_ff @(posedge oscClk or posedge warmClr) begin
    if (warmClr) clrPipe <= 2'b11;
    else         clrPipe <= {clrPipe[0], 1'b0};
  end
  assign oscClr = clrPipe[1];

  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      warmCnt     <= '0;
      warmDoneOsc <= 1'b0;
    end else if (oscClr) begin
      warmCnt     <= '0;
      warmDoneOsc <= 1'b0;
    end else if (oscPresent && !warmDoneOsc) begin
      warmCnt <= warmCnt + 1'b1;
      if (warmCnt == LAST_CNT) warmDoneOsc <= 1'b1;
    end
  end

  clksw_sync #(.STAGES(SYNC_STAGES)) i_doneSync (
    .clk(loopClk), .rstN(porN), .d(warmDoneOsc), .q(stat.warmDone)
  );

  // break-before-make gate pair
  logic loopQ0, loopQ1, loopGate;
  logic oscQ0, oscQ1, oscGate;

  always_ff @(posedge loopClk or negedge porN) begin
    if (!porN) begin
      loopQ0 <= 1'b0;
      loopQ1 <= 1'b0;
    end else begin
      loopQ0 <= cmd.wantLoop & ~oscGate;
      loopQ1 <= loopQ0;
    end
  end

  always_ff @(negedge loopClk or negedge porN) begin
    if (!porN) loopGate <= 1'b0;
    else       loopGate <= loopQ1;
  end

  always_ff @(posedge oscClk or negedge porN) begin
    if (!porN) begin
      oscQ0 <= 1'b0;
      oscQ1 <= 1'b0;
    end else begin
      oscQ0 <= cmd.wantOsc & ~loopGate;
      oscQ1 <= oscQ0;
    end
  end

  always_ff @(negedge oscClk or negedge porN) begin
    if (!porN) oscGate <= 1'b0;
    else       oscGate <= oscQ1;
  end

  clksw_sync #(.STAGES(SYNC_STAGES)) i_oscOnSync (
    .clk(loopClk), .rstN(porN), .d(oscGate), .q(stat.oscGateOn)
  );

  assign stat.loopGateOn = loopGate;
  assign sysClk = (loopClk & loopGate) | (oscClk & oscGate);

  AST_GATES_EXCL: assert property (@(posedge loopClk) disable iff (!porN)
    !(loopGate && oscGate))
    else $error("both clock gates open"); // R10

  AST_GATES_EXCL_OSC: assert property (@(posedge oscClk) disable iff (!porN)
    !(loopGate && oscGate))
    else $error("both clock gates open at oscillator edge"); // R10

endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int GAP_CYCLES = 4
) (
  input  logic        loopClk,
  input  logic        porN,
  input  logic        stopReq,
  input  logic        wakeReq,
  input  logic        selWrEn,
  input  logic        selWrData,
  input  logic        hfWrEn,
  input  logic        hfWrData,
  input  clksw_stat_t stat,
  output clksw_cmd_t  cmd,
  output logic        loopActive,
  output logic        runEn,
  output logic        oscPowerDown
);
  localparam int RCW = $clog2(RESUME_CYCLES + 1);
  localparam int GCW = $clog2(GAP_CYCLES + 1);
  localparam logic [RCW-1:0] RESUME_LAST = RCW'(RESUME_CYCLES - 1);
  localparam logic [GCW-1:0] GAP_LAST    = GCW'(GAP_CYCLES - 1);

  run_state_t     runState;
  src_state_t     srcState;
  logic [RCW-1:0] resumeCnt;
  logic [GCW-1:0] gapCnt;
  logic           selBit, hfOff, warmClearQ, needLow;
  logic           stopping, warmOk, reqOsc;

  // run / stop sequencing
  always_ff @(posedge loopClk or negedge porN) begin
    if (!porN) begin
      runState  <= RUN_RESUME;
      resumeCnt <= '0;
    end else begin
      case (runState)
        RUN_RESUME: begin
          if (resumeCnt == RESUME_LAST) runState <= RUN_ACTIVE;
          else                          resumeCnt <= resumeCnt + 1'b1;
        end
        RUN_ACTIVE: if (stopReq) runState <= RUN_STOPPED;
        RUN_STOPPED: begin
          if (wakeReq) begin
            runState  <= RUN_RESUME;
            resumeCnt <= '0;
          end
        end
        default: runState <= RUN_RESUME;
      endcase
    end
  end

  assign runEn    = (runState == RUN_ACTIVE);
  assign stopping = (runState == RUN_STOPPED);

  // software bits
  always_ff @(posedge loopClk or negedge porN) begin
    if (!porN) begin
      selBit <= 1'b0;
      hfOff  <= 1'b0;
    end else begin
      if (selWrEn) selBit <= selWrData;
      if (hfWrEn) begin
        if (!hfWrData)                 hfOff <= 1'b0;
        else if (selBit && loopActive) hfOff <= 1'b1;
      end
    end
  end

  // warmup restart and stale-done filter
  always_ff @(posedge loopClk or negedge porN) begin
    if (!porN) begin
      warmClearQ <= 1'b1;
      needLow    <= 1'b1;
    end else begin
      warmClearQ <= stopping || hfOff;
      if (warmClearQ)          needLow <= 1'b1;
      else if (!stat.warmDone) needLow <= 1'b0;
    end
  end

  assign warmOk = stat.warmDone && !needLow;
  assign reqOsc = runEn && !selBit && !hfOff && warmOk;

  // source sequencing with a closed-gate gap between owners
  always_ff @(posedge loopClk or negedge porN) begin
    if (!porN) begin
      srcState <= SRC_LOOP;
      gapCnt   <= '0;
    end else begin
      case (srcState)
        SRC_LOOP: if (stopping || reqOsc) begin
          srcState <= SRC_GAP;
          gapCnt   <= '0;
        end
        SRC_OSC: if (stopping || !reqOsc) begin
          srcState <= SRC_GAP;
          gapCnt   <= '0;
        end
        SRC_GAP: begin
          if (gapCnt != GAP_LAST) gapCnt <= gapCnt + 1'b1;
          else if (!stat.loopGateOn && !stat.oscGateOn)
            srcState <= stopping ? SRC_OFF : (reqOsc ? SRC_OSC : SRC_LOOP);
        end
        SRC_OFF: if (!stopping) srcState <= SRC_LOOP;
        default: srcState <= SRC_LOOP;
      endcase
    end
  end

  assign cmd.wantLoop  = (srcState == SRC_LOOP);
  assign cmd.wantOsc   = (srcState == SRC_OSC);
  assign cmd.warmClear = warmClearQ;
  assign loopActive    = (srcState != SRC_OSC);
  assign oscPowerDown  = hfOff;

  AST_SEL_ONLY_WRITE: assert property (@(posedge loopClk) disable iff (!porN)
    !selWrEn |=> $stable(selBit))
    else $error("select bit moved without a write"); // R6

  AST_RUN_DELAY: assert property (@(posedge loopClk) disable iff (!porN)
    $rose(runEn) |-> $past(!runEn, 4))
    else $error("run enable rose too early"); // R8

  AST_HFOFF_GUARD: assert property (@(posedge loopClk) disable iff (!porN)
    $rose(oscPowerDown) |-> $past(selBit && loopActive))
    else $error("oscillator disabled without guard"); // R9

  AST_STOP_DROPS_RUN: assert property (@(posedge loopClk) disable iff (!porN)
    (stopReq && runEn) |=> !runEn)
    else $error("stop did not halt execution"); // R7

  AST_OSC_NEEDS_WARM: assert property (@(posedge loopClk) disable iff (!porN)
    $rose(cmd.wantOsc) |-> stat.warmDone)
    else $error("oscillator chosen before warmup"); // R2

endmodule

// File: rtl/clksw_top.sv
module clksw_top
  import clksw_pkg::*;
#(
  parameter int WARM_CYCLES = 65536,
  parameter int GAP_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic loopClk,
  input  logic oscClk,
  input  logic porN,
  input  logic oscPresent,
  input  logic stopReq,
  input  logic wakeReq,
  input  logic selWrEn,
  input  logic selWrData,
  input  logic hfWrEn,
  input  logic hfWrData,
  output logic sysClk,
  output logic loopActive,
  output logic runEn,
  output logic oscPowerDown
);
  clksw_cmd_t  cmd;
  clksw_stat_t stat;

  clksw_ctrl #(.GAP_CYCLES(GAP_CYCLES)) i_ctrl (
    .loopClk(loopClk), .porN(porN), .stopReq(stopReq), .wakeReq(wakeReq),
    .selWrEn(selWrEn), .selWrData(selWrData), .hfWrEn(hfWrEn), .hfWrData(hfWrData),
    .stat(stat), .cmd(cmd), .loopActive(loopActive), .runEn(runEn),
    .oscPowerDown(oscPowerDown)
  );

  clksw_datapath #(.WARM_CYCLES(WARM_CYCLES), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .loopClk(loopClk), .oscClk(oscClk), .porN(porN), .oscPresent(oscPresent),
    .cmd(cmd), .stat(stat), .sysClk(sysClk)
  );
endmodule

// File: tb/test_clksw_top.sv
`timescale 1ns/1ps
module test_clksw_top;
  logic loopClk = 1'b0, oscClk = 1'b0;
  logic porN = 1'b0, oscPresent = 1'b1;
  logic stopReq = 1'b0, wakeReq = 1'b0;
  logic selWrEn = 1'b0, selWrData = 1'b0, hfWrEn = 1'b0, hfWrData = 1'b0;
  logic sysClk, loopActive, runEn, oscPowerDown;

  int checks = 0, errors = 0;
  bit finished = 0, started = 0;
  int edgeCnt = 0;
  realtime tRise = 0, tFall = 0, minHigh = 1000.0, minLow = 1000.0;

  always #4.0 loopClk = ~loopClk;   // 125 MHz
  always #2.5 oscClk  = ~oscClk;    // 200 MHz

  clksw_top #(.WARM_CYCLES(200), .GAP_CYCLES(4), .SYNC_STAGES(2)) i_clksw_top (
    .loopClk(loopClk), .oscClk(oscClk), .porN(porN), .oscPresent(oscPresent),
    .stopReq(stopReq), .wakeReq(wakeReq), .selWrEn(selWrEn), .selWrData(selWrData),
    .hfWrEn(hfWrEn), .hfWrData(hfWrData), .sysClk(sysClk), .loopActive(loopActive),
    .runEn(runEn), .oscPowerDown(oscPowerDown)
  );

  always @(posedge sysClk) begin
    edgeCnt++;
    if (started && tFall > 0 && ($realtime - tFall) < minLow) minLow = $realtime - tFall;
    tRise = $realtime;
  end
  always @(negedge sysClk) begin
    if (started && tRise > 0 && ($realtime - tRise) < minHigh) minHigh = $realtime - tRise;
    tFall = $realtime;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge loopClk);
  endtask

  // 0 stopped, 1 loop clock, 2 oscillator clock, 3 unclear
  task automatic srcOf(output int src);
    int startCnt, n;
    @(negedge loopClk);
    startCnt = edgeCnt;
    cyc(40);
    n = edgeCnt - startCnt;
    if (n < 5) src = 0;
    else if (n >= 35 && n <= 45) src = 1;
    else if (n >= 58 && n <= 70) src = 2;
    else src = 3;
  endtask

  task automatic selWrite(input logic v);
    @(negedge loopClk); selWrEn = 1'b1; selWrData = v;
    @(negedge loopClk); selWrEn = 1'b0;
  endtask

  task automatic hfWrite(input logic v);
    @(negedge loopClk); hfWrEn = 1'b1; hfWrData = v;
    @(negedge loopClk); hfWrEn = 1'b0;
  endtask

  task automatic doStop();
    @(negedge loopClk); stopReq = 1'b1;
    @(negedge loopClk); stopReq = 1'b0;
  endtask

  task automatic doWake(input string tag);
    @(negedge loopClk); wakeReq = 1'b1;
    @(negedge loopClk); wakeReq = 1'b0;
    cyc(3);
    chk({tag, " runEn low before fourth edge"}, runEn, 0);
    cyc(1);
    chk({tag, " runEn high on fourth edge"}, runEn, 1);
  endtask

  task automatic doPor();
    @(negedge loopClk); porN = 1'b0;
    cyc(3);
    porN = 1'b1;
    cyc(3);
    chk("R1 runEn low three edges after release", runEn, 0);
    cyc(1);
    chk("R1 runEn high four edges after release", runEn, 1);
  endtask

  // [6] sel write [5] sel value [4] disable write [3] disable value
  // [2] expected loopActive [1] expected oscPowerDown [0] expected source is oscillator
  localparam int NVEC = 7;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0011001,  // R9 disable rejected while oscillator runs
    7'b1100100,  // R4 select loop clock
    7'b0011110,  // R9 disable accepted
    7'b1000110,  // R9 select cleared but oscillator stays off
    7'b0010001,  // R9 re-enable, warmup, handover
    7'b1100100,  // R4 back to loop clock
    7'b1000001   // R2 warmup already done: direct handover
  };

  initial begin
    int src;
    // R1 reset state
    cyc(2);
    chk("R1 runEn during reset", runEn, 0);
    chk("R1 loopActive during reset", loopActive, 1);
    chk("R1 oscPowerDown during reset", oscPowerDown, 0);
    started = 1;
    porN = 1'b1;
    cyc(3);
    chk("R1 runEn low three edges after release", runEn, 0);
    cyc(1);
    chk("R1 runEn high four edges after release", runEn, 1);
    srcOf(src);
    chk("R1 source is loop clock during warmup", src, 1);
    chk("R1 loopActive during warmup", loopActive, 1);

    // R2 automatic handover
    cyc(200);
    chk("R2 loopActive after warmup", loopActive, 0);
    srcOf(src);
    chk("R2 source is oscillator after warmup", src, 2);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      @(negedge loopClk);
      selWrEn = VEC[i][6]; selWrData = VEC[i][5];
      hfWrEn  = VEC[i][4]; hfWrData  = VEC[i][3];
      @(negedge loopClk);
      selWrEn = 1'b0; hfWrEn = 1'b0;
      cyc(200);
      chk($sformatf("R9 vector %0d loopActive", i), loopActive, int'(VEC[i][2]));
      chk($sformatf("R9 vector %0d oscPowerDown", i), oscPowerDown, int'(VEC[i][1]));
      srcOf(src);
      chk($sformatf("R4 vector %0d source", i), src, VEC[i][0] ? 2 : 1);
    end

    // R7 wake while running has no effect
    @(negedge loopClk); wakeReq = 1'b1;
    @(negedge loopClk); wakeReq = 1'b0;
    cyc(2);
    chk("R7 wake while running ignored", runEn, 1);
    srcOf(src);
    chk("R7 source unchanged after stray wake", src, 2);

    // R7 stop and wake in the same cycle: stop wins
    @(negedge loopClk); stopReq = 1'b1; wakeReq = 1'b1;
    @(negedge loopClk); stopReq = 1'b0; wakeReq = 1'b0;
    chk("R7 runEn low after stop", runEn, 0);
    cyc(10);
    srcOf(src);
    chk("R7 sysClk stopped", src, 0);

    // R8 wake with select 0: warmup restarts
    doWake("R8");
    cyc(4);
    chk("R8 loopActive right after wake", loopActive, 1);
    srcOf(src);
    chk("R8 source loop clock after wake", src, 1);
    cyc(200);
    chk("R8 loopActive after new warmup", loopActive, 0);

    // R9 disable and select writes in one cycle: disable judged on old select
    @(negedge loopClk); hfWrEn = 1'b1; hfWrData = 1'b1; selWrEn = 1'b1; selWrData = 1'b1;
    @(negedge loopClk); hfWrEn = 1'b0; selWrEn = 1'b0;
    cyc(20);
    chk("R9 same-cycle disable rejected", oscPowerDown, 0);
    chk("R4 same-cycle select honoured", loopActive, 1);
    srcOf(src);
    chk("R4 source loop clock after select", src, 1);

    // R6 select survives stop
    doStop();
    cyc(10);
    doWake("R6");
    cyc(300);
    chk("R6 select kept across stop", loopActive, 1);
    srcOf(src);
    chk("R6 source stays loop clock", src, 1);

    // R5 clear select while warmup is running
    doStop();
    cyc(10);
    doWake("R5");
    selWrite(1'b0);
    cyc(8);
    chk("R5 loopActive holds during warmup", loopActive, 1);
    cyc(200);
    chk("R5 loopActive after warmup", loopActive, 0);

    // R6 only power-on reset clears the select bit
    selWrite(1'b1);
    cyc(30);
    doStop();
    cyc(10);
    doPor();
    cyc(250);
    chk("R6 select cleared by reset", loopActive, 0);
    srcOf(src);
    chk("R6 source oscillator after reset", src, 2);

    // R3 oscillator absent
    doStop();
    cyc(10);
    oscPresent = 1'b0;
    doPor();
    cyc(400);
    chk("R3 loopActive without oscillation", loopActive, 1);
    srcOf(src);
    chk("R3 source loop clock without oscillation", src, 1);

    // R10 no runt pulses
    chk("R10 shortest high phase at least 2.5 ns", int'(minHigh * 10.0) >= 24, 1);
    chk("R10 shortest low phase at least 2.5 ns", int'(minLow * 10.0) >= 24, 1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule